// File: doc/BRIEF.md
# Prioritized Interrupt Routing Controller

This block gathers interrupt requests from a set of on-chip and off-chip sources and turns them into four level-sensitive request lines for a processor core: a critical line, a high-priority system-management line, a low-priority standard line and a machine-check line that never asserts. Each source input is brought into the clock domain by a two-flop synchronizer. A rising edge on a synchronized source sets a sticky pending bit, and that bit stays set until software writes a one to it.

Four sources feed only the critical line: a high-priority DMA request, external request 0, slice timer 0 and a wakeup event. Slice timer 1 always drives the system-management line. Every other source is programmable. A route bit sends it to either the system-management line or the standard line, and a mask bit keeps it off both lines. The system-management line has the higher priority at the core. Apart from that, it behaves exactly like the standard line. A word-wide register port with combinational read-back lets software read the pending bits, clear them, and program the route and mask bits.

The register interface is a plain write strobe with an address. It has no valid/ready handshake because it never stalls: a write takes effect at the clock edge where the strobe is high, and read data follows the address in the same cycle.

Top module: `irq_router`

## Requirements
- R1: `irq_mcheck` is 0 in every cycle, whatever the inputs and register writes.
- R2: `irq_crit` is 1 exactly when at least one of pending bits 0..3 was set in the previous cycle. Those bits belong to DMA-high, external 0, slice timer 0 and wakeup, in that order. The route and mask bits have no effect on `irq_crit`.
- R3: Pending bit 4 (slice timer 1) drives `irq_smi` one cycle later, whatever the route and mask bits hold.
- R4: Programmable source i has pending bit 5+i. Route bit i equal to 1 sends it to `irq_smi`, and 0 sends it to `irq_std`. Mask bit i equal to 1 keeps it off both lines, but its pending bit still shows in the status register.
- R5: Suppose a source is first sampled high at clock edge E0 after being sampled low. Its pending bit is then set after edge E2, and the output line it is routed to asserts after edge E3.
- R6: A pending bit, and the output it drives, stays set after its source input falls, until software clears it.
- R7: A write to address 0 clears every pending bit whose data bit is 1. Bits written as 0 are left unchanged.
- R8: When one of several pending sources routed to the same line is cleared, the line stays asserted without a gap as long as any unmasked source routed to it is still pending.
- R9: If a new rising edge reaches the pending stage in the same cycle as a clear of that bit, the bit stays set.
- R10: The register map is fixed. Address 0 is status: pending bits at positions 0..4+N, read, write-one-to-clear. Address 1 is route, with bit i for programmable source i, read/write. Address 2 is mask, laid out like route, read/write. Address 3 reads as 0, and writes to it change nothing.
- R11: After reset, all pending, route and mask bits are 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_src | input | 4 | Critical sources: DMA-high, external 0, slice timer 0, wakeup |
| st1_src | input | 1 | Slice timer 1 request |
| prog_src | input | NUM_PROG | Programmable sources |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq_crit | output | 1 | Critical request line |
| irq_smi | output | 1 | System-management request line |
| irq_std | output | 1 | Standard request line |
| irq_mcheck | output | 1 | Machine-check line, always inactive |

## Verification
The assertions check the following on every cycle:
- a rising edge always leaves its pending bit set;
- no pending bit drops without a clear;
- a clear without a competing edge empties the bit;
- the critical and slice-timer-1 bits always reach their lines;
- the lines fall silent when nothing unmasked is pending.

Some behaviour can only be shown by the bench's scenarios:
- the exact three-stage latency from pin to line;
- the route and mask steering of each programmable source;
- the absence of a gap when one of two shared requests is cleared;
- the register map, including the address that has no effect.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ROUTE  = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned CRIT_CNT  = 4;
  localparam int unsigned ST1_POS   = CRIT_CNT;
  localparam int unsigned PROG_BASE = CRIT_CNT + 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  // three stages per source: two for metastability, one for edge history
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] pend_q;

  // a clear and a fresh edge in the same cycle: the edge wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | rise;
  end
  assign pend = pend_q;

  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~rise) != '0) |=> ((pend_q & $past(clr & ~rise)) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned NUM_PROG = 8,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned W       = PROG_BASE + NUM_PROG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wen,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [W-1:0]        pend,
  output logic [NUM_PROG-1:0] route,
  output logic [NUM_PROG-1:0] mask,
  output logic [W-1:0]        clr,
  output logic [DATA_W-1:0]   rdata
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route <= '0;
      mask  <= '0;
    end else if (wen) begin
      if (sel == SEL_ROUTE) route <= wdata[NUM_PROG-1:0];
      if (sel == SEL_MASK)  mask  <= wdata[NUM_PROG-1:0];
    end
  end

  assign clr = (wen && sel == SEL_STATUS) ? wdata[W-1:0] : '0;

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_STATUS: rdata[W-1:0]        = pend;
      SEL_ROUTE:  rdata[NUM_PROG-1:0] = route;
      SEL_MASK:   rdata[NUM_PROG-1:0] = mask;
      default:    rdata               = '0;
    endcase
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_pkg::*;
#(
  parameter int unsigned NUM_PROG = 8,
  localparam int unsigned W       = PROG_BASE + NUM_PROG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        pend,
  input  logic [NUM_PROG-1:0] route,
  input  logic [NUM_PROG-1:0] mask,
  output logic                irq_crit,
  output logic                irq_smi,
  output logic                irq_std
);
  logic [NUM_PROG-1:0] live, to_smi, to_std;

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_steer
    assign live[i]   = pend[PROG_BASE+i] & ~mask[i];
    assign to_smi[i] = live[i] &  route[i];
    assign to_std[i] = live[i] & ~route[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_crit <= 1'b0;
      irq_smi  <= 1'b0;
      irq_std  <= 1'b0;
    end else begin
      irq_crit <= |pend[CRIT_CNT-1:0];
      irq_smi  <= pend[ST1_POS] | (|to_smi);
      irq_std  <= |to_std;
    end
  end

  p_crit_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend[CRIT_CNT-1:0]) |=> irq_crit);

  p_st1_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend[ST1_POS] |=> irq_smi);

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend[ST1_POS] && live == '0) |=> (!irq_smi && !irq_std));

  p_all_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> (!irq_crit && !irq_smi && !irq_std));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_pkg::*;
#(
  parameter int unsigned NUM_PROG = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          crit_src,
  input  logic                st1_src,
  input  logic [NUM_PROG-1:0] prog_src,
  input  logic                reg_wen,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_crit,
  output logic                irq_smi,
  output logic                irq_std,
  output logic                irq_mcheck
);
  localparam int unsigned W = PROG_BASE + NUM_PROG;

  logic [W-1:0]        src_all, rise, clr, pend;
  logic [NUM_PROG-1:0] route, mask;

  assign src_all = {prog_src, st1_src, crit_src};

  irq_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(src_all), .rise(rise)
  );

  irq_pending #(.W(W)) u_pend (
    .clk(clk), .rst_n(rst_n), .rise(rise), .clr(clr), .pend(pend)
  );

  irq_regs #(.NUM_PROG(NUM_PROG), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .pend(pend), .route(route), .mask(mask),
    .clr(clr), .rdata(reg_rdata)
  );

  irq_route #(.NUM_PROG(NUM_PROG)) u_route (
    .clk(clk), .rst_n(rst_n), .pend(pend), .route(route), .mask(mask),
    .irq_crit(irq_crit), .irq_smi(irq_smi), .irq_std(irq_std)
  );

  // machine-check line is never driven by any source
  assign irq_mcheck = 1'b0;
endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
  localparam int NP = 8;
  localparam int DW = 32;
  localparam int W  = 5 + NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  src = '0;
  logic          reg_wen = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_crit, irq_smi, irq_std, irq_mcheck;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_router #(.NUM_PROG(NP), .DATA_W(DW)) u_irq_router (
    .clk(clk), .rst_n(rst_n), .crit_src(src[3:0]), .st1_src(src[4]),
    .prog_src(src[W-1:5]), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_crit(irq_crit),
    .irq_smi(irq_smi), .irq_std(irq_std), .irq_mcheck(irq_mcheck)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: source history by age, sticky set, steering sums
  logic [W-1:0]  m_hist [0:2];
  logic [W-1:0]  m_pend;
  logic [NP-1:0] m_route, m_mask;
  logic          m_crit, m_smi, m_std;
  logic [DW-1:0] m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 3; a++) m_hist[a] = '0;
      m_pend = '0; m_route = '0; m_mask = '0;
      m_crit = 0; m_smi = 0; m_std = 0;
    end else begin
      logic [W-1:0] clrv, newe;
      int n_smi, n_std;
      clrv = (reg_wen && reg_addr == 2'd0) ? reg_wdata[W-1:0] : '0;
      newe = m_hist[1] & ~m_hist[2];
      m_crit = (m_pend[3:0] != 0);
      n_smi = m_pend[4] ? 1 : 0;
      n_std = 0;
      for (int k = 0; k < NP; k++)
        if (m_pend[5+k] && !m_mask[k]) begin
          if (m_route[k]) n_smi++; else n_std++;
        end
      m_smi = n_smi > 0;
      m_std = n_std > 0;
      for (int b = 0; b < W; b++)
        if (newe[b]) m_pend[b] = 1'b1; else if (clrv[b]) m_pend[b] = 1'b0;
      if (reg_wen && reg_addr == 2'd1) m_route = reg_wdata[NP-1:0];
      if (reg_wen && reg_addr == 2'd2) m_mask  = reg_wdata[NP-1:0];
      m_hist[2] = m_hist[1]; m_hist[1] = m_hist[0]; m_hist[0] = src;
    end
    #1;
    case (reg_addr)
      2'd0: m_rd = DW'(m_pend);
      2'd1: m_rd = DW'(m_route);
      2'd2: m_rd = DW'(m_mask);
      default: m_rd = '0;
    endcase
    if (!done) begin
      chk("R1 mcheck", DW'(irq_mcheck), '0);
      chk("R2 crit model", DW'(irq_crit), DW'(m_crit));
      chk("R4 smi model", DW'(irq_smi), DW'(m_smi));
      chk("R4 std model", DW'(irq_std), DW'(m_std));
      chk("R10 rdata model", reg_rdata, m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 1'b0; reg_wdata = '0; reg_addr = 2'd0;
  endtask

  task automatic pulse(input int b);
    @(negedge clk); src[b] = 1'b1;
    repeat (2) @(negedge clk);
    src[b] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=hung exp=finish");
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 crit", DW'(irq_crit), '0);
    chk("R11 smi", DW'(irq_smi), '0);
    chk("R11 std", DW'(irq_std), '0);
    rst_n = 1'b1;
    rd(2'd0, '0, "R11 status");
    rd(2'd1, '0, "R11 route");
    rd(2'd2, '0, "R11 mask");

    // R2 critical: slice timer 0 (bit 2), route/mask all ones
    wr(2'd1, 32'hFF); wr(2'd2, 32'hFF);
    pulse(2);
    chk("R2 crit set", DW'(irq_crit), 1);
    chk("R2 no smi", DW'(irq_smi), 0);
    rd(2'd0, 32'h4, "R10 status crit");
    wr(2'd0, 32'h4);
    @(negedge clk);
    chk("R7 crit cleared", DW'(irq_crit), 0);

    // R3 slice timer 1 ignores route=0, mask=all
    wr(2'd1, 32'h0);
    pulse(4);
    chk("R3 smi", DW'(irq_smi), 1);
    chk("R3 std", DW'(irq_std), 0);
    wr(2'd0, 32'h10);
    wr(2'd2, 32'h0);

    // R4 steering of programmable source 0 (bit 5)
    pulse(5);
    chk("R4 route0 std", DW'(irq_std), 1);
    chk("R4 route0 smi", DW'(irq_smi), 0);
    wr(2'd1, 32'h1);
    @(negedge clk);
    chk("R4 route1 smi", DW'(irq_smi), 1);
    chk("R4 route1 std", DW'(irq_std), 0);
    wr(2'd2, 32'h1);
    @(negedge clk);
    chk("R4 masked smi", DW'(irq_smi), 0);
    chk("R4 masked std", DW'(irq_std), 0);
    rd(2'd0, 32'h20, "R4 masked still pending");
    wr(2'd0, 32'h20);
    wr(2'd1, 32'h0); wr(2'd2, 32'h0);

    // R5 latency on source 1 (bit 6), routed to standard
    @(negedge clk); src[6] = 1'b1;          // sampled at E0
    @(negedge clk); @(negedge clk);          // after E1
    @(negedge clk); #0.5;                    // after E2
    chk("R5 pending at E2", reg_rdata & 32'h40, 32'h40);
    chk("R5 line not yet", DW'(irq_std), 0);
    @(negedge clk);                          // after E3
    chk("R5 line at E3", DW'(irq_std), 1);
    src[6] = 1'b0;

    // R6 persistence after source drops
    repeat (10) @(negedge clk);
    chk("R6 std held", DW'(irq_std), 1);

    // R7 writing zeros leaves pending alone
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h40, "R7 zero write");

    // R8 shared line: add bit 7, clear bit 6, line must not dip
    pulse(7);
    @(negedge clk); reg_wen = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h40;
    @(negedge clk); reg_wen = 1'b0; reg_wdata = '0;
    for (int c = 0; c < 4; c++) begin
      chk("R8 shared held", DW'(irq_std), 1);
      @(negedge clk);
    end
    wr(2'd0, 32'h80);
    @(negedge clk);
    chk("R8 last cleared", DW'(irq_std), 0);

    // R9 clear coinciding with a new edge on bit 5
    pulse(5);
    @(negedge clk); src[5] = 1'b1;
    @(negedge clk);
    wr(2'd0, 32'h20);
    src[5] = 1'b0;
    rd(2'd0, 32'h20, "R9 edge wins");
    wr(2'd0, 32'h20);
    rd(2'd0, 32'h0, "R9 then cleared");

    // R10 reserved address
    wr(2'd1, 32'h5A); wr(2'd2, 32'h0C);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R10 addr3 reads 0");
    rd(2'd1, 32'h5A, "R10 route kept");
    rd(2'd2, 32'h0C, "R10 mask kept");
    rd(2'd0, 32'h0, "R10 status kept");
    chk("R1 mcheck end", DW'(irq_mcheck), 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule